// File: doc/BRIEF.md
# Parallel Port Host Register Window

This block is the host-facing register window of a standard-mode parallel port. A host reaches eight byte-wide locations through a simple synchronous bus that carries a byte offset, a write enable and a select. The window keeps the outgoing data byte and the port control byte. The status byte is not stored here: it is computed by a separate reverse-channel sequencer and only passed through, with a sticky interrupt flag folded into one bit.

Every control write is offered to the sequencer as a single-cycle event that carries the old and the new control value side by side, so that the sequencer can detect handshake edges. When the host raises the strobe bit while the sequencer reports forward-idle, the current data byte is sent out with a one-cycle valid pulse. When the sequencer's acknowledge line rises in response to a control write and the newly written control value enables interrupts, a sticky flag is set and a one-cycle interrupt pulse is produced. Reading the status location clears the flag.

Read data and the error response are registered: they are valid in the cycle that follows the access.

Top module: `pport_regfile`

## Requirements
- R1: After reset the control register reads 0x0C, the data register reads 0x00, the interrupt flag is clear, and `rd_data`, `bus_err`, `fwd_valid` and `irq_pulse` are low.
- R2: Offset 0 holds the data byte; a read returns the last value written, whatever the direction bit or sequencer state.
- R3: A read of offset 1 returns `seq_status` as it is in the access cycle, with bit 2 forced to 1 while the interrupt flag is set; it does not set `bus_err`.
- R4: A read of offset 1 clears the interrupt flag; if the flag is set in the same cycle, the read returns the old flag value and the flag stays set.
- R5: Offset 2 holds control bits 5:0 (bit 0 strobe, bit 1 autofeed, bit 2 init, bit 3 select-in, bit 4 interrupt enable, bit 5 direction); bits 7:6 always read as 0.
- R6: In the cycle of a write to offset 2, `ctl_wr` is high, `ctl_prev` carries the control value before the write and `ctl_next` the written value with bits 7:6 zero; `ctl_wr` is low in every other cycle.
- R7: A control write whose bit 0 goes from 0 to 1 while `seq_fwd_idle` is high makes `fwd_valid` high for exactly the next cycle with `fwd_data` equal to the data register; no other write raises `fwd_valid`.
- R8: If status bit 6 was 0 in the cycle of a control write, is 1 in the following cycle, and bit 4 of the written value is 1, the flag is set and `irq_pulse` is high for one cycle, both visible two cycles after the write.
- R9: Reads of offsets 3 to 7 return 0 with no error; writes to them change neither the data nor the control register.
- R10: An access to an offset of 8 or above sets `bus_err` for one cycle, returns 0 and changes no register.
- R11: An acknowledge rise after a control write whose bit 4 is 0 sets no flag and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_off | input | OFF_W | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the access |
| bus_err | output | 1 | Error response for out-of-window offsets |
| seq_status | input | 8 | Status byte from the reverse-channel sequencer |
| seq_fwd_idle | input | 1 | Sequencer is in forward-idle |
| ctl_wr | output | 1 | Control write event this cycle |
| ctl_prev | output | 8 | Control value before the write |
| ctl_next | output | 8 | Control value being written |
| ctl_q | output | 8 | Current control register |
| fwd_data | output | 8 | Forward data byte |
| fwd_valid | output | 1 | Forward byte valid, one cycle |
| irq_pulse | output | 1 | Interrupt edge, one cycle |

## Verification
The flag can be set by an acknowledge rise and cleared by a status read in the same cycle. The bench provokes this by writing control with interrupts enabled while acknowledge is low, then reading status in the very next cycle while presenting acknowledge high; it expects the read to show bit 2 clear and the next status read to show it set. Random traffic, with randomly changing status bytes and forward-idle, also lands strobe edges, acknowledge rises and status reads on shared cycles, and a bench model judges every response.

// File: rtl/pport_regfile.sv
module pport_regfile #(
  parameter int         OFF_W     = 4,
  parameter logic [7:0] CTL_RESET = 8'h0C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [OFF_W-1:0] bus_off,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             bus_err,
  input  logic [7:0]       seq_status,
  input  logic             seq_fwd_idle,
  output logic             ctl_wr,
  output logic [7:0]       ctl_prev,
  output logic [7:0]       ctl_next,
  output logic [7:0]       ctl_q,
  output logic [7:0]       fwd_data,
  output logic             fwd_valid,
  output logic             irq_pulse
);
  localparam int CTL_W   = 6;
  localparam int ACK_BIT = 6;
  localparam int FLG_BIT = 2;
  localparam int STB_BIT = 0;
  localparam int IEN_BIT = 4;

  logic [7:0]       data_q;
  logic [CTL_W-1:0] ctl_r;
  logic             flag_q, pend_q, ackb_q, ien_q;
  logic [7:0]       rd_val;

  wire       in_win   = (bus_off >> 3) == '0;
  wire [2:0] idx      = bus_off[2:0];
  wire       rd       = bus_sel & ~bus_we;
  wire       wr       = bus_sel & bus_we & in_win;
  wire       rd_stat  = rd & in_win & (idx == 3'd1);
  wire       ack_rise = pend_q & ~ackb_q & seq_status[ACK_BIT] & ien_q;
  wire       stb_rise = ctl_wr & ~ctl_r[STB_BIT] & bus_wdata[STB_BIT];

  assign ctl_wr   = wr & (idx == 3'd2);
  assign ctl_prev = {{(8-CTL_W){1'b0}}, ctl_r};
  assign ctl_next = {{(8-CTL_W){1'b0}}, bus_wdata[CTL_W-1:0]};
  assign ctl_q    = ctl_prev;

  always_comb begin
    rd_val = '0;
    if (in_win) begin
      case (idx)
        3'd0:    rd_val = data_q;
        3'd1:    rd_val = seq_status | (8'(flag_q) << FLG_BIT);
        3'd2:    rd_val = ctl_prev;
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q    <= '0;
      ctl_r     <= CTL_RESET[CTL_W-1:0];
      flag_q    <= 1'b0;
      pend_q    <= 1'b0;
      ackb_q    <= 1'b0;
      ien_q     <= 1'b0;
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      fwd_data  <= '0;
      fwd_valid <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      bus_rdata <= rd ? rd_val : '0;
      bus_err   <= bus_sel & ~in_win;
      if (wr && idx == 3'd0) data_q <= bus_wdata;
      if (ctl_wr) ctl_r <= bus_wdata[CTL_W-1:0];
      pend_q    <= ctl_wr;
      ackb_q    <= seq_status[ACK_BIT];
      ien_q     <= bus_wdata[IEN_BIT];
      irq_pulse <= ack_rise;
      if (ack_rise)     flag_q <= 1'b1;
      else if (rd_stat) flag_q <= 1'b0;
      fwd_valid <= stb_rise & seq_fwd_idle;
      if (stb_rise && seq_fwd_idle) fwd_data <= data_q;
    end
  end
endmodule

// File: rtl/pport_regfile_chk.sv
module pport_regfile_chk #(
  parameter int OFF_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [OFF_W-1:0] bus_off,
  input logic [7:0]       bus_rdata,
  input logic             bus_err,
  input logic             ctl_wr,
  input logic [7:0]       ctl_next,
  input logic [7:0]       ctl_q,
  input logic [7:0]       data_q,
  input logic             flag_q,
  input logic             fwd_valid,
  input logic             irq_pulse
);
  wire hi_off  = bus_sel && bus_off >= OFF_W'(3) && bus_off <= OFF_W'(7);
  wire rd_st   = bus_sel && !bus_we && bus_off == OFF_W'(1);

  // R7
  fwd_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> $past(ctl_wr));

  // R6
  ctl_takes_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ctl_q == $past(ctl_next));

  // R8
  irq_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> flag_q);

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  // R4
  read_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_st |=> (!flag_q || irq_pulse));

  // R9
  high_regs_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_off |=> ($stable(data_q) && $stable(ctl_q) && bus_rdata == 8'h00 && !bus_err));

  // R10
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_rdata == 8'h00);
endmodule

bind pport_regfile pport_regfile_chk #(.OFF_W(OFF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_off(bus_off),
  .bus_rdata(bus_rdata), .bus_err(bus_err), .ctl_wr(ctl_wr), .ctl_next(ctl_next),
  .ctl_q(ctl_q), .data_q(data_q), .flag_q(flag_q), .fwd_valid(fwd_valid),
  .irq_pulse(irq_pulse)
);

// File: tb/tb_pport_regfile.sv
module tb_pport_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_off = '0;
  logic [7:0] bus_wdata = '0, seq_status = 8'hD8;
  logic       seq_fwd_idle = 1'b1;
  logic [7:0] bus_rdata, ctl_prev, ctl_next, ctl_q, fwd_data;
  logic       bus_err, ctl_wr, fwd_valid, irq_pulse;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_data = 8'h00;
  logic [5:0] m_ctl = 6'h0C;
  logic m_flag = 0, m_pend = 0, m_ackb = 0, m_ien = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pport_regfile dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .seq_status(seq_status), .seq_fwd_idle(seq_fwd_idle), .ctl_wr(ctl_wr),
    .ctl_prev(ctl_prev), .ctl_next(ctl_next), .ctl_q(ctl_q), .fwd_data(fwd_data),
    .fwd_valid(fwd_valid), .irq_pulse(irq_pulse)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] f_read(logic [3:0] off, logic [7:0] st);
    if (off >= 4'd8) return 8'h00;
    case (off)
      4'd0:    return m_data;
      4'd1:    return st | (m_flag ? 8'h04 : 8'h00);
      4'd2:    return {2'b00, m_ctl};
      default: return 8'h00;
    endcase
  endfunction

  task automatic op(bit we, logic [3:0] off, logic [7:0] wd, logic [7:0] st, bit idle);
    logic [7:0] e_rd, e_fd;
    bit e_err, e_irq, e_fwd, e_cw, no_ien;
    string rtag;
    seq_status = st; seq_fwd_idle = idle;
    bus_sel = 1; bus_we = we; bus_off = off; bus_wdata = wd;
    #1;
    e_rd   = we ? 8'h00 : f_read(off, st);
    e_err  = off >= 4'd8;
    e_irq  = m_pend && !m_ackb && st[6] && m_ien;
    no_ien = m_pend && !m_ackb && st[6] && !m_ien;
    e_cw   = we && off == 4'd2;
    e_fwd  = e_cw && !m_ctl[0] && wd[0] && idle;
    e_fd   = m_data;
    check("R6", {31'd0, ctl_wr}, {31'd0, e_cw});
    if (e_cw) begin
      check("R6", {24'd0, ctl_prev}, {26'd0, m_ctl});
      check("R6", {24'd0, ctl_next}, {26'd0, wd[5:0]});
    end
    if (off == 4'd1 && (m_flag || e_irq)) rtag = "R4";
    else if (off == 4'd0) rtag = "R2";
    else if (off == 4'd1) rtag = "R3";
    else if (off == 4'd2) rtag = "R5";
    else if (off < 4'd8)  rtag = "R9";
    else                  rtag = "R10";
    if (e_irq) m_flag = 1;
    else if (!we && off == 4'd1) m_flag = 0;
    if (we && off == 4'd0) m_data = wd;
    if (e_cw) m_ctl = wd[5:0];
    m_pend = e_cw; m_ackb = st[6]; m_ien = wd[4];
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    if (!we) check(rtag, {24'd0, bus_rdata}, {24'd0, e_rd});
    check("R10", {31'd0, bus_err}, {31'd0, e_err});
    check("R7", {31'd0, fwd_valid}, {31'd0, e_fwd});
    if (e_fwd) check("R7", {24'd0, fwd_data}, {24'd0, e_fd});
    check(no_ien ? "R11" : "R8", {31'd0, irq_pulse}, {31'd0, e_irq});
    check("R5", {24'd0, ctl_q}, {26'd0, m_ctl});
  endtask

  initial begin
    int unsigned seed = 32'd2024;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1", {24'd0, ctl_q}, 32'h0C);
    check("R1", {28'd0, bus_rdata, irq_pulse, fwd_valid, bus_err} >> 0,
          32'd0);
    op(0, 4'd0, 8'h00, 8'hD8, 1);
    op(0, 4'd1, 8'h00, 8'hD8, 1);
    // R2 loopback with direction bit set and sequencer busy
    op(1, 4'd0, 8'hA5, 8'hD8, 1);
    op(1, 4'd2, 8'h2C, 8'h58, 0);
    op(0, 4'd0, 8'h00, 8'h58, 0);
    // R7 strobe rise while idle, then held high, then not idle
    op(1, 4'd2, 8'h0C, 8'hD8, 1);
    op(1, 4'd2, 8'h0D, 8'hD8, 1);
    op(1, 4'd2, 8'h0D, 8'hD8, 1);
    op(1, 4'd2, 8'h0C, 8'hD8, 0);
    op(1, 4'd2, 8'h0D, 8'hD8, 0);
    // R9 high offsets ignore writes
    for (int o = 3; o < 8; o++) op(1, 4'(o), 8'hFF, 8'hD8, 1);
    for (int o = 3; o < 8; o++) op(0, 4'(o), 8'h00, 8'hD8, 1);
    op(0, 4'd0, 8'h00, 8'hD8, 1);
    op(0, 4'd2, 8'h00, 8'hD8, 1);
    // R10 out-of-window
    op(1, 4'd9, 8'h55, 8'hD8, 1);
    op(0, 4'd15, 8'h00, 8'hD8, 1);
    op(0, 4'd2, 8'h00, 8'hD8, 1);
    // R8 acknowledge rise with interrupts enabled, plain reads after
    op(1, 4'd2, 8'h10, 8'h98, 1);
    op(0, 4'd0, 8'h00, 8'hD8, 1);
    op(0, 4'd0, 8'h00, 8'hD8, 1);
    op(0, 4'd1, 8'h00, 8'hD8, 1);
    op(0, 4'd1, 8'h00, 8'hD8, 1);
    // R4 status read in the same cycle the flag is set
    op(1, 4'd2, 8'h12, 8'h98, 1);
    op(0, 4'd1, 8'h00, 8'hD8, 1);
    op(0, 4'd1, 8'h00, 8'hD8, 1);
    op(0, 4'd1, 8'h00, 8'hD8, 1);
    // R11 rise with interrupts disabled in the new value
    op(1, 4'd2, 8'h00, 8'h98, 1);
    op(0, 4'd1, 8'h00, 8'hD8, 1);
    // random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] off;
      int r = $urandom_range(0, 9);
      off = (r < 4) ? 4'd2 : (r < 6) ? 4'd1 : (r < 8) ? 4'd0 : 4'($urandom_range(0, 15));
      op(1'($urandom_range(0, 1)), off, 8'($urandom), 8'($urandom), 1'($urandom_range(0, 1)));
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule